// File: doc/BRIEF.md
# Memory Test Write-Pattern Source

This block supplies the write side of a memory test engine with data words and their byte-enable vectors. Every word it hands out is one user-clock word. It covers `NUM_PINS` data pins over `RATIO` memory beats, so each pin contributes a serial pattern `RATIO` bits long. Data can come from a 31-bit pseudo-random sequence, which is the default, or from fixed patterns. A fixed pattern can be one pattern shared by all pins, or a separate pattern for each pin. Byte enables have their own independent choice of source. They can come from a second pseudo-random sequence or from fixed masks, and the fixed masks can be shared by all lanes or set lane by lane.

The output is a valid/ready stream. A word is transferred on a rising clock edge where `out_valid` and `out_ready` are both high. The next word is then presented in the following cycle with no gap. While the consumer holds `out_ready` low, the presented word and its enables stay frozen. Configuration changes take effect from the next word loaded, not on the word already presented.

Pulsing `restart` reloads both sequence seeds, so the read-checking side can regenerate the same stream. Pattern configuration inputs are plain levels and are meant to be held steady while words are being drawn.

Top module: `mtpg_top`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0. The first word is presented one cycle after reset is released, built from the seeds `DATA_SEED` and `MASK_SEED`.
- R2: A word transfers on each rising edge with `out_valid` and `out_ready` both high. The next word is presented in the following cycle, and `out_valid` stays high until a restart.
- R3: While `out_valid` is high and `out_ready` is low, `out_data` and `out_be` hold their values.
- R4: Pseudo-random data uses a Fibonacci register of 31 bits, state s[30:0], with taps x^31+x^28+1. One step computes f = s[30]^s[27] and shifts to {s[29:0], f}. A word takes W consecutive steps, and step i supplies f as word bit i (bit 0 first). Here W = `NUM_PINS*RATIO`. The register advances only when a word is loaded.
- R5: Word bit [b*NUM_PINS + p] is beat b of data pin p. With `data_fixed`=1 and `data_all_pins`=1, that bit equals `pat_all[b]`.
- R6: With `data_fixed`=1 and `data_all_pins`=0, bit [b*NUM_PINS + p] equals `pat_pin[p*RATIO + b]`.
- R7: With `be_test`=0, every bit of `out_be` is 1, whatever the enable-mode inputs are.
- R8: With `be_test`=1 and `be_fixed`=0, `out_be` comes from a second register of the same form as R4, seeded with `MASK_SEED`. It takes `NUM_PINS*RATIO/8` steps per word, and step k sets lane k. A 1 lets a byte be written and a 0 masks it.
- R9: With `be_test`=1 and `be_fixed`=1, `out_be` is `be_all` copied to every lane when `be_all_lanes`=1, and `be_lane` otherwise.
- R10: A `restart` pulse reloads both seeds and drops `out_valid` for one cycle. The words that follow repeat the sequence from R1. Both registers advance once per loaded word, whatever the modes are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| restart | input | 1 | Reload both seeds and refill the output |
| data_fixed | input | 1 | 0: pseudo-random data, 1: fixed pattern |
| data_all_pins | input | 1 | Fixed mode: 1 shares `pat_all` across pins |
| pat_all | input | RATIO | Shared per-pin pattern, bit b is beat b |
| pat_pin | input | NUM_PINS*RATIO | Per-pin patterns, pin p at [p*RATIO +: RATIO] |
| be_test | input | 1 | 0: all bytes enabled, 1: apply enable pattern |
| be_fixed | input | 1 | 0: pseudo-random enables, 1: fixed masks |
| be_all_lanes | input | 1 | Fixed masks: 1 uses `be_all` for every lane |
| be_all | input | 1 | Shared lane enable |
| be_lane | input | NUM_PINS*RATIO/8 | Individual lane enables |
| out_valid | output | 1 | Word presented |
| out_ready | input | 1 | Consumer accepts the presented word |
| out_data | output | NUM_PINS*RATIO | Data word |
| out_be | output | NUM_PINS*RATIO/8 | Byte enables, 1 = write |

## Verification
The assertions watch the stream rules every cycle. They check that the word is held under back-pressure, that valid stays up once raised, that a restart causes a one-cycle bubble and the refill follows it, and that enables are all ones when masking is off. They also check that neither sequence register ever reaches the all-zero lock-up state. The actual word contents can only be shown by the bench's scenarios, which compare them against an independent model. These include the bit order of the pseudo-random words, the placement of beats and pins for shared and per-pin patterns, and the lane order of the enables. The same goes for exact replay after a restart.

// File: rtl/mtpg_pkg.sv
package mtpg_pkg;
  localparam int LFSR_W = 31;
  localparam int TAP_HI = 30;
  localparam int TAP_LO = 27;
  typedef logic [LFSR_W-1:0] lfsr_t;
endpackage

// File: rtl/mtpg_lfsr.sv
module mtpg_lfsr #(
  parameter int                   OUT_W = 32,
  parameter logic [30:0]          SEED  = 31'h1234_5678
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reload,
  input  logic             advance,
  output logic [OUT_W-1:0] bits
);
  import mtpg_pkg::*;

  lfsr_t state_q;
  lfsr_t state_nx;

  // Unrolled OUT_W single steps from the held state.
  always_comb begin
    lfsr_t s;
    logic  f;
    s    = state_q;
    bits = '0;
    for (int i = 0; i < OUT_W; i++) begin
      f       = s[TAP_HI] ^ s[TAP_LO];
      bits[i] = f;
      s       = {s[LFSR_W-2:0], f};
    end
    state_nx = s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       state_q <= SEED;
    else if (reload)  state_q <= SEED;
    else if (advance) state_q <= state_nx;
  end

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0); // R4
endmodule

// File: rtl/mtpg_data_sel.sv
module mtpg_data_sel #(
  parameter int NUM_PINS = 8,
  parameter int RATIO    = 4,
  localparam int DW      = NUM_PINS * RATIO
) (
  input  logic [DW-1:0]    prbs_bits,
  input  logic             data_fixed,
  input  logic             data_all_pins,
  input  logic [RATIO-1:0] pat_all,
  input  logic [DW-1:0]    pat_pin,
  output logic [DW-1:0]    word
);
  logic [DW-1:0] fixed_word;

  for (genvar b = 0; b < RATIO; b++) begin : g_beat
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      assign fixed_word[b*NUM_PINS + p] =
        data_all_pins ? pat_all[b] : pat_pin[p*RATIO + b];
    end
  end

  assign word = data_fixed ? fixed_word : prbs_bits;
endmodule

// File: rtl/mtpg_be_sel.sv
module mtpg_be_sel #(
  parameter int BW = 4
) (
  input  logic [BW-1:0] prbs_bits,
  input  logic          be_test,
  input  logic          be_fixed,
  input  logic          be_all_lanes,
  input  logic          be_all,
  input  logic [BW-1:0] be_lane,
  output logic [BW-1:0] be
);
  always_comb begin
    if (!be_test)          be = '1;
    else if (!be_fixed)    be = prbs_bits;
    else if (be_all_lanes) be = {BW{be_all}};
    else                   be = be_lane;
  end
endmodule

// File: rtl/mtpg_top.sv
module mtpg_top #(
  parameter int          NUM_PINS  = 8,
  parameter int          RATIO     = 4,
  parameter logic [30:0] DATA_SEED = 31'h1234_5678,
  parameter logic [30:0] MASK_SEED = 31'h0ACE_1357,
  localparam int         DW        = NUM_PINS * RATIO,
  localparam int         BW        = DW / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             data_fixed,
  input  logic             data_all_pins,
  input  logic [RATIO-1:0] pat_all,
  input  logic [DW-1:0]    pat_pin,
  input  logic             be_test,
  input  logic             be_fixed,
  input  logic             be_all_lanes,
  input  logic             be_all,
  input  logic [BW-1:0]    be_lane,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [DW-1:0]    out_data,
  output logic [BW-1:0]    out_be
);
  logic          load;
  logic          step;
  logic [DW-1:0] d_bits;
  logic [BW-1:0] m_bits;
  logic [DW-1:0] d_word;
  logic [BW-1:0] m_word;

  assign load = !out_valid || out_ready;
  assign step = load && !restart;

  mtpg_lfsr #(.OUT_W(DW), .SEED(DATA_SEED)) u_data_lfsr (
    .clk(clk), .rst_n(rst_n), .reload(restart), .advance(step), .bits(d_bits));

  mtpg_lfsr #(.OUT_W(BW), .SEED(MASK_SEED)) u_mask_lfsr (
    .clk(clk), .rst_n(rst_n), .reload(restart), .advance(step), .bits(m_bits));

  mtpg_data_sel #(.NUM_PINS(NUM_PINS), .RATIO(RATIO)) u_data_sel (
    .prbs_bits(d_bits), .data_fixed(data_fixed), .data_all_pins(data_all_pins),
    .pat_all(pat_all), .pat_pin(pat_pin), .word(d_word));

  mtpg_be_sel #(.BW(BW)) u_be_sel (
    .prbs_bits(m_bits), .be_test(be_test), .be_fixed(be_fixed),
    .be_all_lanes(be_all_lanes), .be_all(be_all), .be_lane(be_lane), .be(m_word));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_be    <= '0;
    end else if (restart) begin
      out_valid <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= d_word;
      out_be    <= m_word;
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> $stable(out_data) && $stable(out_be)); // R3
  AST_VALID_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !restart |=> out_valid); // R2
  AST_RESTART_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !out_valid); // R10
  AST_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid && !restart |=> out_valid); // R1
  AST_BE_ALL_ON: assert property (@(posedge clk) disable iff (!rst_n)
    load && !restart && !be_test |=> &out_be); // R7
endmodule

// File: tb/mtpg_top_tb.sv
module mtpg_top_tb;
  localparam int          NP  = 8;
  localparam int          RT  = 4;
  localparam int          DW  = NP * RT;
  localparam int          BW  = DW / 8;
  localparam logic [30:0] DS  = 31'h1234_5678;
  localparam logic [30:0] MS  = 31'h0ACE_1357;

  logic clk = 0, rst_n = 0, restart = 0;
  logic data_fixed = 0, data_all_pins = 0, be_test = 0, be_fixed = 0;
  logic be_all_lanes = 0, be_all = 0, out_ready = 0;
  logic [RT-1:0] pat_all = '0;
  logic [DW-1:0] pat_pin = '0;
  logic [BW-1:0] be_lane = '0;
  logic          out_valid;
  logic [DW-1:0] out_data;
  logic [BW-1:0] out_be;

  int checks = 0, fails = 0;
  logic [30:0] md, mm;   // model states

  always #2.5 clk = ~clk;

  mtpg_top #(.NUM_PINS(NP), .RATIO(RT), .DATA_SEED(DS), .MASK_SEED(MS)) u_dut (
    .clk(clk), .rst_n(rst_n), .restart(restart), .data_fixed(data_fixed),
    .data_all_pins(data_all_pins), .pat_all(pat_all), .pat_pin(pat_pin),
    .be_test(be_test), .be_fixed(be_fixed), .be_all_lanes(be_all_lanes),
    .be_all(be_all), .be_lane(be_lane), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_be(out_be));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_bits(inout logic [30:0] s, input int n, output logic [DW-1:0] w);
    logic f;
    w = '0;
    for (int i = 0; i < n; i++) begin
      f = s[30] ^ s[27];
      w[i] = f;
      s = {s[29:0], f};
    end
  endtask

  // Next model data word and mask bits; both registers step each word (R10).
  task automatic model_next(output logic [DW-1:0] dw, output logic [BW-1:0] mb);
    logic [DW-1:0] t;
    model_bits(md, DW, dw);
    model_bits(mm, BW, t);
    mb = t[BW-1:0];
  endtask

  task automatic take(output logic [DW-1:0] d, output logic [BW-1:0] b);
    @(negedge clk);
    while (!out_valid) @(negedge clk);
    d = out_data; b = out_be;
    out_ready = 1;
    @(negedge clk);
    out_ready = 0;
  endtask

  task automatic do_restart();
    @(negedge clk); restart = 1;
    @(negedge clk); restart = 0;
    check("R10 bubble", out_valid, 0);
    md = DS; mm = MS;
  endtask

  task automatic t_reset();
    logic [DW-1:0] ed; logic [BW-1:0] eb;
    rst_n = 0;
    repeat (3) @(negedge clk);
    check("R1 valid in reset", out_valid, 0);
    rst_n = 1;
    md = DS; mm = MS;
    @(negedge clk);
    check("R1 first valid", out_valid, 1);
    model_next(ed, eb);
    check("R1 first word", out_data, ed);
    check("R7 be off", out_be, {BW{1'b1}});
  endtask

  task automatic t_prbs_stream();
    logic [DW-1:0] d, ed; logic [BW-1:0] b, eb;
    take(d, b);   // first word already modelled
    check("R2 first accepted", out_valid, 1);
    for (int k = 0; k < 5; k++) begin
      model_next(ed, eb);
      take(d, b);
      check("R4 prbs word", d, ed);
      check("R7 be all on", b, {BW{1'b1}});
    end
  endtask

  task automatic t_stall();
    logic [DW-1:0] d, ed, held; logic [BW-1:0] b, eb;
    model_next(ed, eb);
    @(negedge clk);
    held = out_data;
    repeat (4) @(negedge clk);
    check("R3 data held", out_data, held);
    check("R2 valid held", out_valid, 1);
    take(d, b);
    check("R4 stalled word", d, ed);
    model_next(ed, eb);
    take(d, b);
    check("R2 after stall", d, ed);
  endtask

  task automatic t_fixed_shared();
    logic [DW-1:0] d, ed; logic [BW-1:0] b, eb;
    data_fixed = 1; data_all_pins = 1; pat_all = 4'b1010;
    do_restart();
    model_next(ed, eb);
    take(d, b);
    check("R5 shared pattern", d, 32'hFF00_FF00);
    pat_all = 4'b0011;
    model_next(ed, eb);
    take(d, b);   // loaded with previous pattern
    model_next(ed, eb);
    take(d, b);
    check("R5 shared pattern 2", d, 32'h0000_FFFF);
  endtask

  task automatic t_fixed_pin();
    logic [DW-1:0] d, ed, ex; logic [BW-1:0] b, eb;
    data_fixed = 1; data_all_pins = 0; pat_pin = 32'h9C3A_61E5;
    do_restart();
    for (int bt = 0; bt < RT; bt++)
      for (int p = 0; p < NP; p++)
        ex[bt*NP + p] = pat_pin[p*RT + bt];
    model_next(ed, eb);
    take(d, b);
    check("R6 per-pin pattern", d, ex);
  endtask

  task automatic t_mask_modes();
    logic [DW-1:0] d, ed; logic [BW-1:0] b, eb;
    data_fixed = 0; be_test = 1; be_fixed = 0;
    do_restart();
    for (int k = 0; k < 3; k++) begin
      model_next(ed, eb);
      take(d, b);
      check("R8 prbs be", b, eb);
      check("R10 data in step", d, ed);
    end
    be_fixed = 1; be_all_lanes = 1; be_all = 0;
    do_restart();
    model_next(ed, eb);
    take(d, b);
    check("R9 shared be 0", b, 0);
    be_all_lanes = 0; be_lane = 4'b0101;
    do_restart();
    model_next(ed, eb);
    take(d, b);
    check("R9 lane be", b, 4'b0101);
    be_test = 0;
    do_restart();
    model_next(ed, eb);
    take(d, b);
    check("R7 be ignored", b, {BW{1'b1}});
  endtask

  task automatic t_replay();
    logic [DW-1:0] d; logic [BW-1:0] b;
    logic [DW-1:0] cap [3];
    logic [BW-1:0] capb [3];
    data_fixed = 0; be_test = 1; be_fixed = 0;
    do_restart();
    for (int k = 0; k < 3; k++) take(cap[k], capb[k]);
    do_restart();
    for (int k = 0; k < 3; k++) begin
      take(d, b);
      check("R10 replay data", d, cap[k]);
      check("R10 replay be", b, capb[k]);
    end
  endtask

  initial begin
    t_reset();
    t_prbs_stream();
    t_stall();
    t_fixed_shared();
    t_fixed_pin();
    t_mask_modes();
    t_replay();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule